// File: doc/BRIEF.md
# Multicycle Logic-Operation Processor Core

This core is a small register-based processor driven by a single state machine. It holds eight 8-bit general registers, a program counter and an instruction register. It reads its program from an external instruction memory that answers in the same cycle. It presents an address and samples the returned word before the next rising edge.

After reset the core spends eight cycles filling its registers from memory words 0 to 7, one register per cycle. It then repeats a three-cycle loop. The first cycle fetches the word at the program counter into the instruction register. The second cycle steps the program counter and selects an execute state from the opcode. The third cycle writes the result of a two-operand bitwise operation back into the first named register.

Debug outputs show every register and the program counter, so a test environment can follow the architectural state cycle by cycle.

Top module: `mcycle_cpu`

## Requirements
- R1: While rst_ni is low the program counter, the address output and every register read 0. Reset is asynchronous and active low, and it restarts the preload sequence.
- R2: In the k-th cycle after reset is released (k = 0 to 7), the address output equals k and register k captures the memory word at the next rising edge. The program counter reads 8 once the preload is done.
- R3: After the preload, the core repeats three cycles per instruction: fetch, program-counter step, execute. The address output always equals the program counter.
- R4: The program counter rises by exactly one per instruction, at the end of the step cycle. It does not change in the fetch or execute cycles.
- R5: An instruction word is opcode[7:6], first index[5:3] and second index[2:0]. Opcode 2'b00 writes first AND second into the first register.
- R6: Opcode 2'b01 writes first XOR second into the first register.
- R7: Opcode 2'b10 writes the bitwise complement of the second register into the first register. The old value of the first register has no effect.
- R8: Opcode 2'b11 writes first OR second into the first register.
- R9: An instruction changes no register other than its first named register.
- R10: When both indices name the same register, the operation uses that register's old value for both operands.
- R11: The program counter wraps from 255 to 0, and execution continues with words 0 to 7 treated as instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Instruction memory address |
| imem_data_i | input | 8 | Instruction memory word, combinational |
| dbg_regs_o | output | 64 | Register k on bits [8k+7:8k] |
| dbg_pc_o | output | 8 | Program counter |

## Verification
Two things can happen in the same cycle: a register write and a read of that same register. In the execute cycle the first register is both a source and the destination, and when the two indices match, both operands read the register being written. The program generator places same-index instructions at fixed addresses, for example XOR of a register with itself, which must give zero, and NOT of a register onto itself. The reference model in the bench computes each result from the old register values and compares all eight registers on every cycle. A design that forwarded the new value, or corrupted a neighbour register, shows a miscompare in the cycle after the write.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_XOR = 2'b01,
    OP_NOT = 2'b10,
    OP_OR  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_PRELOAD,
    ST_FETCH,
    ST_STEP,
    ST_EX_AND,
    ST_EX_XOR,
    ST_EX_NOT,
    ST_EX_OR
  } state_e;
endpackage

// File: rtl/logic_alu.sv
module logic_alu
  import cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/reg_file.sv
module reg_file #(
  parameter int W     = 8,
  parameter int NREGS = 8,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IW-1:0]      waddr_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [IW-1:0]      raddr_a_i,
  input  logic [IW-1:0]      raddr_b_i,
  output logic [W-1:0]       rdata_a_o,
  output logic [W-1:0]       rdata_b_o,
  output logic [NREGS*W-1:0] flat_o
);
  logic [W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (we_i && waddr_i == IW'(g))       regs_q[g] <= wdata_i;
    end
    assign flat_o[g*W +: W] = regs_q[g];
  end

  // read-before-write: operands come from the old contents
  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R9: without a write enable no register moves
  p_hold_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flat_o));
endmodule

// File: rtl/cpu_fsm.sv
module cpu_fsm
  import cpu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   preload_last_i,
  input  op_e    op_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PRELOAD: state_d = preload_last_i ? ST_FETCH : ST_PRELOAD;
      ST_FETCH:   state_d = ST_STEP;
      ST_STEP: begin
        unique case (op_i)
          OP_AND:  state_d = ST_EX_AND;
          OP_XOR:  state_d = ST_EX_XOR;
          OP_NOT:  state_d = ST_EX_NOT;
          OP_OR:   state_d = ST_EX_OR;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_EX_AND, ST_EX_XOR, ST_EX_NOT, ST_EX_OR: state_d = ST_FETCH;
      default: state_d = ST_PRELOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PRELOAD;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_fetch_to_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |=> state_q == ST_STEP);
  p_exec_to_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_EX_AND, ST_EX_XOR, ST_EX_NOT, ST_EX_OR}) |=> state_q == ST_FETCH);
  p_preload_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PRELOAD |=> state_q inside {ST_PRELOAD, ST_FETCH});
endmodule

// File: rtl/mcycle_cpu.sv
module mcycle_cpu
  import cpu_pkg::*;
#(
  parameter int W      = 8,
  parameter int NREGS  = 8,
  parameter int ADDR_W = 8,
  localparam int IW    = $clog2(NREGS),
  localparam int OP_LO = 2 * IW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [W-1:0]       imem_data_i,
  output logic [NREGS*W-1:0] dbg_regs_o,
  output logic [ADDR_W-1:0]  dbg_pc_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [W-1:0]      ir_q;
  state_e            state;
  op_e               ir_op;
  logic [IW-1:0]     idx_a, idx_b, waddr;
  logic [W-1:0]      opa, opb, alu_res, wdata;
  logic              preload, execute, we, preload_last;

  assign ir_op   = op_e'(ir_q[OP_LO +: 2]);
  assign idx_a   = ir_q[IW +: IW];
  assign idx_b   = ir_q[0 +: IW];
  assign preload = (state == ST_PRELOAD);
  assign execute = state inside {ST_EX_AND, ST_EX_XOR, ST_EX_NOT, ST_EX_OR};
  assign preload_last = (pc_q == ADDR_W'(NREGS - 1));

  cpu_fsm i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .preload_last_i (preload_last),
    .op_i           (ir_op),
    .state_o        (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (state == ST_FETCH)                pc_q <= pc_q;
      if (preload || state == ST_STEP)      pc_q <= pc_q + 1'b1;
      if (state == ST_FETCH)                ir_q <= imem_data_i;
    end
  end

  logic_alu #(.W(W)) i_alu (
    .op_i  (ir_op),
    .a_i   (opa),
    .b_i   (opb),
    .res_o (alu_res)
  );

  assign we    = preload || execute;
  assign waddr = preload ? pc_q[IW-1:0] : idx_a;
  assign wdata = preload ? imem_data_i : alu_res;

  reg_file #(.W(W), .NREGS(NREGS)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (idx_a),
    .raddr_b_i (idx_b),
    .rdata_a_o (opa),
    .rdata_b_o (opb),
    .flat_o    (dbg_regs_o)
  );

  assign imem_addr_o = pc_q;
  assign dbg_pc_o    = pc_q;

  p_pc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_STEP |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));
  p_pc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (execute || state == ST_FETCH) |=> $stable(pc_q));
  p_preload_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload && preload_last) |=> pc_q == ADDR_W'(NREGS));
endmodule

// File: tb/test_mcycle_cpu.sv
module test_mcycle_cpu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr, imem_data, dbg_pc;
  logic [63:0] dbg_regs;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // program image: words 0..7 preload data, fixed same-index slots
  function automatic logic [7:0] mem_word(input logic [7:0] a);
    logic [7:0] v;
    if (a < 8) return (a * 8'h4B) ^ 8'h5A;
    if (a[4:0] == 5'd9)  return {a[7:6], 3'd3, 3'd3};
    if (a[4:0] == 5'd20) return {2'b10, 3'd5, 3'd5};
    v = (a * 8'd29 + 8'd7) ^ {3'b0, a[7:3]};
    return v;
  endfunction

  assign imem_data = mem_word(imem_addr);

  mcycle_cpu i_mcycle_cpu (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .dbg_regs_o  (dbg_regs),
    .dbg_pc_o    (dbg_pc)
  );

  // behavioural reference model
  int         m_phase;   // 0 preload, 1 fetch, 2 step, 3 execute
  logic [7:0] m_pc, m_ir;
  logic [7:0] m_regs [8];
  bit         m_valid = 0, m_wrapped = 0;
  int         m_last_wr = -1;
  string      m_tag = "R1";

  always @(posedge clk) begin
    m_valid   <= 1'b1;
    m_last_wr = -1;
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_ir = 0; m_wrapped = 0; m_tag = "R1";
      foreach (m_regs[k]) m_regs[k] = 0;
    end else begin
      case (m_phase)
        0: begin
          m_regs[m_pc[2:0]] = mem_word(m_pc);
          m_last_wr = int'(m_pc[2:0]);
          if (m_pc == 7) m_phase = 1;
          m_pc = m_pc + 1; m_tag = "R2";
        end
        1: begin m_ir = mem_word(m_pc); m_phase = 2; m_tag = "R3"; end
        2: begin
          if (m_pc == 8'hFF) m_wrapped = 1;
          m_pc = m_pc + 1; m_phase = 3; m_tag = "R4";
        end
        default: begin
          logic [7:0] a, b, r;
          int i1, i2;
          i1 = int'(m_ir[5:3]); i2 = int'(m_ir[2:0]);
          a = m_regs[i1]; b = m_regs[i2];
          case (m_ir[7:6])
            2'b00: begin r = a & b; m_tag = "R5"; end
            2'b01: begin r = a ^ b; m_tag = "R6"; end
            2'b10: begin r = ~b;    m_tag = "R7"; end
            default: begin r = a | b; m_tag = "R8"; end
          endcase
          if (i1 == i2) m_tag = "R10";
          else if (m_wrapped) m_tag = "R11";
          m_regs[i1] = r; m_last_wr = i1; m_phase = 1;
        end
      endcase
    end
  end

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (m_valid) begin
      string ptag;
      ptag = (m_tag == "R2" || m_tag == "R1") ? m_tag : (m_wrapped ? "R11" : "R4");
      check8(ptag, "pc", dbg_pc, m_pc);
      check8(m_tag == "R1" ? "R1" : "R3", "addr", imem_addr, m_pc);
      for (int k = 0; k < 8; k++)
        check8((m_last_wr == k || m_tag == "R1" || m_tag == "R2") ? m_tag : "R9",
               $sformatf("reg%0d", k), dbg_regs[k*8 +: 8], m_regs[k]);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (1000) @(negedge clk);   // covers wrap past address 255
    #1 rst_n = 1'b0;                // asynchronous reset mid-run
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (400) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule